// File: doc/BRIEF.md
# Fractional-N Divide Value Modulator

This block sits beside the feedback divider of a fractional-N synthesizer. It produces the integer divide value to use for the next reference period. The value wanders around a programmed integer part so that its long-run average is the integer part plus a 21-bit binary fraction. The noise shaping comes from a cascade of one, two or three 21-bit accumulators. Their carries are combined through error-cancelling delay terms, and the number of stages in use can be changed at runtime. A pseudo-random dither of a selectable power-of-two size can be added to the first accumulator to break up idle tones.

The block advances once for each cycle in which the reference-rate enable is high. In every such cycle it registers a new divide value. The divider counter that consumes the value lies outside this block.

Top module: `frac_dsm`

## Requirements
- R1: While reset is held, and after reset until the first enabled cycle, `div_out` is 45. The stored order after reset is third order, so an enabled cycle with `order_sel` = 3 directly after reset takes a modulator step and does not clear. With integer 45, fraction 0x100000 and no dither, the first two outputs are 45 and 47.
- R2: With `order_sel` = 0 (modulator off), every enabled cycle registers the clamped integer part. The fraction and the dither have no effect, and all accumulators and delay terms are held at zero.
- R3: An integer input above 255 is treated as 255 in every order.
- R4: With `order_sel` = 1 (single stage) and dither off, N enabled steps from a cleared state sum to exactly N·I + floor(N·F/2^21). Every output is I or I+1.
- R5: With `order_sel` = 2 (two stages) and dither off, the sum over N steps from a cleared state exceeds N·I + floor(N·F/2^21) by 0 or 1. Every output lies in I−1 to I+2.
- R6: With `order_sel` = 3 (three stages) and dither off, the sum over N steps from a cleared state lies between −1 and +2 of N·I + floor(N·F/2^21). Every output lies in I−3 to I+4.
- R7: An enabled cycle whose `order_sel` differs from the one stored at the previous enabled cycle registers the clamped integer only. It clears every accumulator and delay term, so the next step starts from zero.
- R8: When `ce` is low, `div_out` and all modulator state hold their values.
- R9: `dith_gain` code g = 0 adds no dither. Codes 1 to 7 add ±2^(g−1) LSBs (1 up to 64) to the first accumulator input in each enabled cycle. The sign is taken from a 23-bit maximal-length shift register with taps at stages 23 and 18. With fraction 0 and code 7 at a single stage, outputs of I−1 and I+1 occur, and the sum of offsets stays near zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Reference-rate step enable |
| int_in | input | 9 | Integer part of the divide ratio |
| frac_in | input | 21 | Fraction numerator over 2^21 |
| order_sel | input | 2 | Modulator order: 0 off, 1 to 3 stages |
| dith_gain | input | 3 | Dither size code |
| div_out | output | 11 | Registered divide value, two's complement |

## Verification
An order change can land in the same enabled cycle in which the first accumulator is about to carry. The bench provokes this by running a single stage at a fraction of one half until the accumulator holds a half, then switching to two stages in the next enabled cycle. The clear must win: that cycle shows the bare integer, and the two following values show a restart from zero (I, then I+1) rather than the pending carry. A second coincidence, a held `ce` in the middle of a carry pattern, is judged by checking that the pattern resumes at the same phase.

// File: rtl/frac_dsm.sv
module frac_dsm #(
  parameter int INT_W   = 9,
  parameter int FRAC_W  = 21,
  parameter int GAIN_W  = 3,
  parameter int INT_MAX = 255,
  parameter int INT_RST = 45,
  localparam int OUT_W  = INT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [1:0]        order_sel,
  input  logic [GAIN_W-1:0] dith_gain,
  output logic [OUT_W-1:0]  div_out
);
  localparam int SW = FRAC_W + 3;
  localparam int LW = 23;

  logic [LW-1:0]     lfsr;
  logic [FRAC_W-1:0] a1, a2, a3;
  logic              c2d, c3d, c3dd;
  logic [1:0]        ord_q;

  logic [INT_W-1:0]  int_c;
  logic signed [SW-1:0] dmag, dith, s1;
  logic signed [2:0] c1;
  logic [FRAC_W-1:0] a1n, a2n, a3n;
  logic [FRAC_W:0]   s2, s3;
  logic              c2, c3, chg, off_mode;
  int                off;

  assign int_c = (int_in > INT_W'(INT_MAX)) ? INT_W'(INT_MAX) : int_in;

  always_comb begin
    dmag = '0;
    if (dith_gain != '0) dmag = SW'(1) << (dith_gain - 1'b1);
  end
  assign dith = lfsr[0] ? dmag : -dmag;

  assign s1  = $signed({3'b000, a1}) + $signed({3'b000, frac_in}) + dith;
  assign c1  = s1[SW-1:FRAC_W];
  assign a1n = s1[FRAC_W-1:0];
  assign s2  = {1'b0, a2} + {1'b0, a1n};
  assign c2  = s2[FRAC_W];
  assign a2n = s2[FRAC_W-1:0];
  assign s3  = {1'b0, a3} + {1'b0, a2n};
  assign c3  = s3[FRAC_W];
  assign a3n = s3[FRAC_W-1:0];

  always_comb begin
    off = int'(c1);
    if (order_sel[1]) off = off + int'(c2) - int'(c2d);
    if (order_sel == 2'd3) off = off + int'(c3) - 2 * int'(c3d) + int'(c3dd);
  end

  assign chg      = order_sel != ord_q;
  assign off_mode = chg || order_sel == 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr    <= '1;
      a1      <= '0;
      a2      <= '0;
      a3      <= '0;
      c2d     <= 1'b0;
      c3d     <= 1'b0;
      c3dd    <= 1'b0;
      ord_q   <= 2'd3;
      div_out <= OUT_W'(INT_RST);
    end else if (ce) begin
      ord_q <= order_sel;
      lfsr  <= {lfsr[LW-2:0], lfsr[LW-1] ^ lfsr[17]};
      if (off_mode) begin
        a1      <= '0;
        a2      <= '0;
        a3      <= '0;
        c2d     <= 1'b0;
        c3d     <= 1'b0;
        c3dd    <= 1'b0;
        div_out <= {2'b00, int_c};
      end else begin
        a1      <= a1n;
        a2      <= order_sel[1] ? a2n : '0;
        c2d     <= order_sel[1] ? c2 : 1'b0;
        a3      <= (order_sel == 2'd3) ? a3n : '0;
        c3d     <= (order_sel == 2'd3) ? c3 : 1'b0;
        c3dd    <= (order_sel == 2'd3) ? c3d : 1'b0;
        div_out <= OUT_W'(int'(int_c) + off);
      end
    end
  end

  logic signed [OUT_W-1:0] out_s, int_s;
  assign out_s = $signed(div_out);
  assign int_s = $signed({2'b00, int_c});

  a_r2_off_integer: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && order_sel == 2'd0) |=> (out_s == $past(int_s) && a1 == '0 && a2 == '0 && a3 == '0));

  a_r3_clamp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && order_sel == 2'd0) |=> (out_s <= OUT_W'(INT_MAX)));

  a_r4_first_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && order_sel == 2'd1 && !chg && dith_gain == '0)
      |=> (out_s - $past(int_s) >= 0 && out_s - $past(int_s) <= 1));

  a_r6_third_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && order_sel != 2'd0 && dith_gain == '0)
      |=> (out_s - $past(int_s) >= -3 && out_s - $past(int_s) <= 4));

  a_r7_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && chg) |=> (a1 == '0 && a2 == '0 && a3 == '0 && !c2d && !c3d && !c3dd
                     && out_s == $past(int_s)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(div_out) && $stable(a1) && $stable(a2) && $stable(a3) && $stable(lfsr)));

  a_r9_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: tb/frac_dsm_tb.sv
`timescale 1ns/1ps
module frac_dsm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic [8:0]  int_in = 9'd45;
  logic [20:0] frac_in = 21'h100000;
  logic [1:0]  order_sel = 2'd3;
  logic [2:0]  dith_gain = 3'd0;
  logic [10:0] div_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  frac_dsm u_dut (.clk(clk), .rst_n(rst_n), .ce(ce), .int_in(int_in), .frac_in(frac_in),
                  .order_sel(order_sel), .dith_gain(dith_gain), .div_out(div_out));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [8:0]  iv;
    logic [20:0] fv;
    logic [1:0]  ov;
    int          lo;
    int          hi;
  } vec_t;

  localparam int NV = 8;
  localparam int NSTEP = 1024;
  localparam vec_t VEC [NV] = '{
    '{9'd100, 21'h0AAAAA, 2'd1, 0, 0},
    '{9'd3,   21'h1FFFFF, 2'd1, 0, 0},
    '{9'd45,  21'h000001, 2'd2, 0, 1},
    '{9'd200, 21'h155555, 2'd2, 0, 1},
    '{9'd45,  21'h100000, 2'd3, -1, 2},
    '{9'd255, 21'h0F0F0F, 2'd3, -1, 2},
    '{9'h1F0, 21'h080000, 2'd3, -1, 2},
    '{9'd77,  21'h123456, 2'd0, 0, 0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint outv();
    return longint'($signed(div_out));
  endfunction

  function automatic longint clampi(input logic [8:0] v);
    return (v > 9'd255) ? 255 : longint'(v);
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint sum, base, mn, mx, o, iv, lo_r, hi_r;
    int nz;
    repeat (3) @(negedge clk);
    chk(outv() == 45, "R1 in reset", outv(), 45);
    rst_n = 1'b1;
    step();
    chk(outv() == 45, "R1 after reset", outv(), 45);
    step();
    chk(outv() == 45, "R8 idle after reset", outv(), 45);
    ce = 1'b1;
    step();
    chk(outv() == 45, "R1 first step", outv(), 45);
    step();
    chk(outv() == 47, "R1 second step", outv(), 47);

    for (int v = 0; v < NV; v++) begin
      iv = clampi(VEC[v].iv);
      int_in = VEC[v].iv;
      frac_in = VEC[v].fv;
      order_sel = 2'd0;
      step();
      order_sel = VEC[v].ov;
      step();
      chk(outv() == iv, (VEC[v].ov == 0) ? "R2 off cycle" : "R7 change cycle", outv(), iv);
      sum = 0;
      mn = 1000;
      mx = -1000;
      for (int k = 0; k < NSTEP; k++) begin
        step();
        o = outv() - iv;
        sum += o;
        if (o < mn) mn = o;
        if (o > mx) mx = o;
      end
      base = (VEC[v].ov == 0) ? 0 : ((longint'(NSTEP) * longint'(VEC[v].fv)) >> 21);
      case (VEC[v].ov)
        2'd0: begin lo_r = 0;  hi_r = 0; end
        2'd1: begin lo_r = 0;  hi_r = 1; end
        2'd2: begin lo_r = -1; hi_r = 2; end
        default: begin lo_r = -3; hi_r = 4; end
      endcase
      chk(sum - base >= VEC[v].lo && sum - base <= VEC[v].hi,
          (VEC[v].ov == 0) ? "R2 sum" : (VEC[v].ov == 1) ? "R4 sum" :
          (VEC[v].ov == 2) ? "R5 sum" : "R6 sum", sum, base);
      chk(mn >= lo_r && mx <= hi_r,
          (VEC[v].iv > 9'd255) ? "R3 clamped range" : "R4 R5 R6 offset range", mx, hi_r);
    end

    int_in = 9'd60;
    frac_in = 21'h100000;
    order_sel = 2'd0;
    step();
    order_sel = 2'd1;
    step();
    chk(outv() == 60, "R7 change to single", outv(), 60);
    step();
    chk(outv() == 60, "R4 half step1", outv(), 60);
    step();
    chk(outv() == 61, "R4 half step2", outv(), 61);
    ce = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(outv() == 61, "R8 hold", outv(), 61);
    end
    ce = 1'b1;
    step();
    chk(outv() == 60, "R8 resume phase", outv(), 60);
    step();
    chk(outv() == 61, "R8 resume carry", outv(), 61);
    step();
    chk(outv() == 60, "R4 half step5", outv(), 60);
    order_sel = 2'd2;
    step();
    chk(outv() == 60, "R7 clear beats carry", outv(), 60);
    step();
    chk(outv() == 60, "R7 restart step1", outv(), 60);
    step();
    chk(outv() == 61, "R7 restart step2", outv(), 61);

    int_in = 9'h1FF;
    frac_in = 21'd0;
    order_sel = 2'd0;
    step();
    chk(outv() == 255, "R3 clamp off", outv(), 255);
    order_sel = 2'd1;
    step();
    step();
    chk(outv() == 255, "R3 clamp single", outv(), 255);

    int_in = 9'd50;
    order_sel = 2'd0;
    step();
    order_sel = 2'd1;
    step();
    nz = 0;
    for (int k = 0; k < 32; k++) begin
      step();
      if (outv() != 50) nz++;
    end
    chk(nz == 0, "R9 no dither", nz, 0);
    dith_gain = 3'd7;
    nz = 0;
    sum = 0;
    mn = 1000;
    mx = -1000;
    for (int k = 0; k < 256; k++) begin
      step();
      o = outv() - 50;
      sum += o;
      if (o != 0) nz++;
      if (o < mn) mn = o;
      if (o > mx) mx = o;
    end
    chk(nz > 0, "R9 dither active", nz, 1);
    chk(mn >= -1 && mx <= 1, "R9 dither offset range", mx, 1);
    chk(sum >= -3 && sum <= 3, "R9 dither mean", sum, 0);
    dith_gain = 3'd0;
    order_sel = 2'd0;
    frac_in = 21'h0AAAAA;
    step();
    chk(outv() == 50, "R2 ignores fraction", outv(), 50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule